// File: doc/BRIEF.md
# Command-Driven Storage Register with Write Flag

This block is a single synchronous storage word, 1 to 64 bits wide, that carries out exactly one operation on each rising clock edge. A 4-bit command code selects the operation. The operations are:

- keep the stored value
- take the data input
- step the stored value up or down by one
- take the data input stepped up or down by one
- load one of two build-time constants
- return to the reset value

A build-time parameter names the operation that runs when no command is presented. An unused code also runs that operation.

Next to the word sits a one-bit write flag. It is raised by every operation that stores a data value: a plain load, the two stepped loads, and the write-constant load. It stays raised until a separate clear strobe drops it. When a flag-raising operation and the clear strobe arrive in the same cycle, the flag stays raised. Loading the other constant, the set-constant load, never raises the flag. A consumer can therefore use the flag to see whether new data was written since it last cleared it.

The stored word drives the data output. When the output-enable variant is built in, the output reads zero while the enable is low.

Top module: `cmd_reg`

## Requirements
- R1: While `rst_ni` is low, the stored word equals RESET_VAL and the flag is 0, independent of the clock. After `rst_ni` rises, the block ignores commands for two more clock edges.
- R2: Code 1 (hold) leaves the stored word unchanged.
- R3: Code 2 stores `din_i`. Code 5 stores `din_i + 1`. Code 6 stores `din_i - 1`. Both stepped results are taken modulo 2^WIDTH.
- R4: Code 3 adds one to the stored word and code 4 subtracts one. Both wrap modulo 2^WIDTH, so all-ones steps up to zero and zero steps down to all-ones.
- R5: Code 7 stores WR_CONST and code 8 stores SET_CONST.
- R6: Code 9 stores RESET_VAL. It leaves the flag as it is, apart from the effect of the clear strobe.
- R7: Code 0 (no command) and codes 10 to 15 carry out the operation selected by DEFAULT_CMD.
- R8: After a clock edge with code 2, 5, 6 or 7 in effect, including through the default, the flag is 1.
- R9: `sem_clr_i` drops the flag at the clock edge unless a flag-raising operation runs in the same cycle. Codes 1, 3, 4, 8 and 9 never raise the flag.
- R10: With HAS_OE=1, `dout_o` reads zero while `oe_i` is low and shows the stored word while `oe_i` is high. The stored word is not disturbed either way. With HAS_OE=0, `dout_o` always shows the stored word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cmd_i | input | 4 | Command code for this cycle |
| din_i | input | WIDTH | Data input for the load operations |
| sem_clr_i | input | 1 | Strobe that clears the write flag |
| oe_i | input | 1 | Output enable (used only when HAS_OE=1) |
| dout_o | output | WIDTH | Stored word, gated by the output enable |
| sem_o | output | 1 | Write flag |

## Verification
Every cycle, the assertions check the following:

- hold keeps the word
- a load stores the input
- increment and decrement step the word by one with wrap-around
- the reset command restores the reset value
- explicit flag-raising codes leave the flag set
- the clear strobe drops the flag under non-raising codes
- the set-constant load does not touch the flag

Some behaviours depend on the build parameters and on the pin-level timing, so only the bench scenarios can show them:

- the mapping of the no-command code and the unused codes onto the default operation
- the output enable gating zero without disturbing the stored word
- the asynchronous reset taking effect before any clock edge
- the two-edge hold-off after reset release

The bench's reference model applies all of these rules cycle by cycle over directed and pseudo-random command streams.

// File: rtl/cmd_reg_pkg.sv
package cmd_reg_pkg;

  localparam int unsigned CMD_W = 4;

  // Command codes seen on cmd_i; codes 10..15 are unused and map to the default
  typedef enum logic [CMD_W-1:0] {
    CMD_NONE  = 4'd0,
    CMD_HOLD  = 4'd1,
    CMD_LOAD  = 4'd2,
    CMD_INC   = 4'd3,
    CMD_DEC   = 4'd4,
    CMD_LDINC = 4'd5,
    CMD_LDDEC = 4'd6,
    CMD_WRC   = 4'd7,
    CMD_SETC  = 4'd8,
    CMD_RST   = 4'd9
  } cmd_code_e;

  // True for operations that store data and therefore raise the write flag
  function automatic logic cmd_sets_flag(cmd_code_e op);
    return (op == CMD_LOAD) || (op == CMD_LDINC) ||
           (op == CMD_LDDEC) || (op == CMD_WRC);
  endfunction

endpackage

// File: rtl/cmd_reg_rst_sync.sv
module cmd_reg_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_no = sync_q[STAGES-1];

endmodule

// File: rtl/cmd_reg_decode.sv
module cmd_reg_decode
  import cmd_reg_pkg::*;
#(
  parameter cmd_code_e DEFAULT_CMD = CMD_HOLD
) (
  input  logic [CMD_W-1:0] cmd_i,
  output cmd_code_e        op_o,
  output logic             sets_flag_o
);

  // A default outside the operation set collapses to hold
  localparam cmd_code_e DFLT_OP =
    (DEFAULT_CMD == CMD_NONE || DEFAULT_CMD > CMD_RST) ? CMD_HOLD : DEFAULT_CMD;

  always_comb begin
    unique case (cmd_i)
      CMD_HOLD, CMD_LOAD, CMD_INC, CMD_DEC, CMD_LDINC,
      CMD_LDDEC, CMD_WRC, CMD_SETC, CMD_RST: op_o = cmd_code_e'(cmd_i);
      default:                               op_o = DFLT_OP;
    endcase
  end

  assign sets_flag_o = cmd_sets_flag(op_o);

endmodule

// File: rtl/cmd_reg_next.sv
module cmd_reg_next
  import cmd_reg_pkg::*;
#(
  parameter int unsigned             WIDTH     = 8,
  parameter logic [WIDTH-1:0]        RESET_VAL = '0,
  parameter logic [WIDTH-1:0]        WR_CONST  = '0,
  parameter logic [WIDTH-1:0]        SET_CONST = '0
) (
  input  cmd_code_e        op_i,
  input  logic [WIDTH-1:0] cur_i,
  input  logic [WIDTH-1:0] din_i,
  output logic [WIDTH-1:0] nxt_o,
  output logic             en_o
);

  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  logic [WIDTH-1:0] cur_up, cur_dn, din_up, din_dn;

  assign cur_up = cur_i + ONE;
  assign cur_dn = cur_i - ONE;
  assign din_up = din_i + ONE;
  assign din_dn = din_i - ONE;

  always_comb begin
    en_o  = 1'b1;
    nxt_o = cur_i;
    unique case (op_i)
      CMD_LOAD:  nxt_o = din_i;
      CMD_INC:   nxt_o = cur_up;
      CMD_DEC:   nxt_o = cur_dn;
      CMD_LDINC: nxt_o = din_up;
      CMD_LDDEC: nxt_o = din_dn;
      CMD_WRC:   nxt_o = WR_CONST;
      CMD_SETC:  nxt_o = SET_CONST;
      CMD_RST:   nxt_o = RESET_VAL;
      default:   en_o  = 1'b0;
    endcase
  end

endmodule

// File: rtl/cmd_reg_flag.sv
module cmd_reg_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);

  logic flag_q, flag_d, flag_en;

  // Raising wins over clearing in the same cycle
  always_comb begin
    flag_en = set_i | clr_i;
    flag_d  = set_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
    end else if (flag_en) begin
      flag_q <= flag_d;
    end
  end

  assign flag_o = flag_q;

endmodule

// File: rtl/cmd_reg.sv
module cmd_reg
  import cmd_reg_pkg::*;
#(
  parameter int unsigned      WIDTH       = 8,
  parameter logic [WIDTH-1:0] RESET_VAL   = '0,
  parameter logic [WIDTH-1:0] WR_CONST    = '1,
  parameter logic [WIDTH-1:0] SET_CONST   = '0,
  parameter cmd_code_e        DEFAULT_CMD = CMD_HOLD,
  parameter bit               HAS_OE      = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [3:0]       cmd_i,
  input  logic [WIDTH-1:0] din_i,
  input  logic             sem_clr_i,
  input  logic             oe_i,
  output logic [WIDTH-1:0] dout_o,
  output logic             sem_o
);

  logic             rst_sync_n;
  cmd_code_e        op;
  logic             sets_flag;
  logic [WIDTH-1:0] word_q, word_d;
  logic             word_en;

  cmd_reg_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_sync_n)
  );

  cmd_reg_decode #(.DEFAULT_CMD(DEFAULT_CMD)) u_decode (
    .cmd_i       (cmd_i),
    .op_o        (op),
    .sets_flag_o (sets_flag)
  );

  cmd_reg_next #(
    .WIDTH     (WIDTH),
    .RESET_VAL (RESET_VAL),
    .WR_CONST  (WR_CONST),
    .SET_CONST (SET_CONST)
  ) u_next (
    .op_i  (op),
    .cur_i (word_q),
    .din_i (din_i),
    .nxt_o (word_d),
    .en_o  (word_en)
  );

  // Storage word, async clear from the primary reset, sync release
  always_ff @(posedge clk_i or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      word_q <= RESET_VAL;
    end else if (word_en) begin
      word_q <= word_d;
    end
  end

  cmd_reg_flag u_flag (
    .clk_i  (clk_i),
    .rst_ni (rst_sync_n),
    .set_i  (sets_flag),
    .clr_i  (sem_clr_i),
    .flag_o (sem_o)
  );

  generate
    if (HAS_OE) begin : g_oe
      assign dout_o = oe_i ? word_q : '0;
    end else begin : g_no_oe
      logic unused_oe;
      assign unused_oe = oe_i;
      assign dout_o    = word_q;
    end
  endgenerate

endmodule

// File: rtl/cmd_reg_chk.sv
module cmd_reg_chk #(
  parameter int unsigned      WIDTH     = 8,
  parameter logic [WIDTH-1:0] RESET_VAL = '0,
  parameter logic [WIDTH-1:0] SET_CONST = '0
) (
  input logic             clk_i,
  input logic             rst_n,
  input logic [3:0]       cmd_i,
  input logic [WIDTH-1:0] din_i,
  input logic             sem_clr_i,
  input logic [WIDTH-1:0] word_q,
  input logic             sem_o
);

  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  AST_HOLD_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_n)
    cmd_i == 4'd1 |=> $stable(word_q)); // R2

  AST_LOAD_TAKES_DIN: assert property (@(posedge clk_i) disable iff (!rst_n)
    cmd_i == 4'd2 |=> word_q == $past(din_i)); // R3

  AST_INC_WRAPS: assert property (@(posedge clk_i) disable iff (!rst_n)
    cmd_i == 4'd3 |=> word_q == $past(word_q) + ONE); // R4

  AST_DEC_WRAPS: assert property (@(posedge clk_i) disable iff (!rst_n)
    cmd_i == 4'd4 |=> word_q == $past(word_q) - ONE); // R4

  AST_SETC_VALUE: assert property (@(posedge clk_i) disable iff (!rst_n)
    cmd_i == 4'd8 |=> word_q == SET_CONST); // R5

  AST_RST_CMD_VALUE: assert property (@(posedge clk_i) disable iff (!rst_n)
    cmd_i == 4'd9 |=> word_q == RESET_VAL); // R6

  AST_FLAG_RAISED: assert property (@(posedge clk_i) disable iff (!rst_n)
    (cmd_i == 4'd2 || cmd_i == 4'd5 || cmd_i == 4'd6 || cmd_i == 4'd7) |=> sem_o); // R8

  AST_FLAG_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_n)
    (sem_clr_i && (cmd_i == 4'd1 || cmd_i == 4'd3 || cmd_i == 4'd4 ||
                   cmd_i == 4'd8 || cmd_i == 4'd9)) |=> !sem_o); // R9

  AST_SETC_NO_FLAG: assert property (@(posedge clk_i) disable iff (!rst_n)
    (cmd_i == 4'd8 && !sem_clr_i) |=> sem_o == $past(sem_o)); // R9

endmodule

bind cmd_reg cmd_reg_chk #(
  .WIDTH     (WIDTH),
  .RESET_VAL (RESET_VAL),
  .SET_CONST (SET_CONST)
) u_chk (
  .clk_i     (clk_i),
  .rst_n     (rst_sync_n),
  .cmd_i     (cmd_i),
  .din_i     (din_i),
  .sem_clr_i (sem_clr_i),
  .word_q    (word_q),
  .sem_o     (sem_o)
);

// File: tb/cmd_reg_tb_top.sv
module cmd_reg_tb_top;
  import cmd_reg_pkg::*;

  localparam int unsigned W     = 8;
  localparam int          MASK  = 'hFF;
  localparam int          RVAL  = 'h5A;
  localparam int          WRC   = 'hC3;
  localparam int          SETC  = 'h3C;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [3:0]   cmd;
  logic [W-1:0] din;
  logic         sem_clr;
  logic         oe;
  logic [W-1:0] dout;
  logic         sem;

  int checks = 0;
  int fails  = 0;
  int model_q;
  int model_sem;
  bit done = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  cmd_reg #(
    .WIDTH       (W),
    .RESET_VAL   (8'h5A),
    .WR_CONST    (8'hC3),
    .SET_CONST   (8'h3C),
    .DEFAULT_CMD (CMD_INC),
    .HAS_OE      (1'b1)
  ) dut_i (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .cmd_i     (cmd),
    .din_i     (din),
    .sem_clr_i (sem_clr),
    .oe_i      (oe),
    .dout_o    (dout),
    .sem_o     (sem)
  );

  task automatic check(input string req, input int got_d, input int got_s,
                       input int exp_d, input int exp_s);
    checks++;
    if (got_d != exp_d || got_s != exp_s) begin
      fails++;
      $display("FAIL %s: dout=%0h sem=%0d expected dout=%0h sem=%0d",
               req, got_d, got_s, exp_d, exp_s);
    end
  endtask

  // Reference model: one clock edge
  task automatic model_edge(input int c, input int d, input bit clr);
    int op;
    bit raise;
    op = (c >= 1 && c <= 9) ? c : 3; // default is increment (R7)
    raise = 1'b0;
    case (op)
      2: begin model_q = d;                 raise = 1'b1; end
      3: model_q = (model_q + 1) & MASK;
      4: model_q = (model_q - 1) & MASK;
      5: begin model_q = (d + 1) & MASK;    raise = 1'b1; end
      6: begin model_q = (d - 1) & MASK;    raise = 1'b1; end
      7: begin model_q = WRC;               raise = 1'b1; end
      8: model_q = SETC;
      9: model_q = RVAL;
      default: ;
    endcase
    if (raise)    model_sem = 1;
    else if (clr) model_sem = 0;
  endtask

  // Drive after a falling edge, update model at rising edge, compare at next falling edge
  task automatic step(input int c, input int d, input bit clr, input bit en,
                      input string req);
    cmd = c[3:0]; din = d[W-1:0]; sem_clr = clr; oe = en;
    @(posedge clk);
    model_edge(c, d, clr);
    @(negedge clk);
    check(req, int'(dout), int'(sem), en ? model_q : 0, model_sem);
  endtask

  task automatic do_reset();
    @(negedge clk);
    cmd = 4'd1; sem_clr = 1'b0; oe = 1'b1; din = '0;
    #3 rst_n = 1'b0;
    #1 check("R1 async", int'(dout), int'(sem), RVAL, 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    // Load during the hold-off must be ignored
    cmd = 4'd2; din = 8'h77;
    repeat (2) @(negedge clk);
    check("R1 release", int'(dout), int'(sem), RVAL, 0);
    cmd = 4'd1;
    model_q = RVAL; model_sem = 0;
  endtask

  initial begin
    int seed;
    rst_n = 1'b0; cmd = 4'd1; din = '0; sem_clr = 1'b0; oe = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 in reset", int'(dout), int'(sem), RVAL, 0);
    do_reset();

    step(1, 'h00, 0, 1, "R2 hold");
    step(1, 'h11, 0, 1, "R2 hold");
    step(2, 'hFF, 0, 1, "R3 load / R8");
    step(3, 'h00, 0, 1, "R4 inc wrap");
    step(4, 'h00, 0, 1, "R4 dec wrap");
    step(4, 'h00, 0, 1, "R4 dec");
    step(1, 'h00, 1, 1, "R9 clear");
    step(5, 'hFF, 0, 1, "R3 ldinc wrap / R8");
    step(2, 'h42, 1, 1, "R9 raise beats clear");
    step(1, 'h00, 1, 1, "R9 clear");
    step(6, 'h00, 0, 1, "R3 lddec wrap");
    step(8, 'h00, 0, 1, "R5 setc / R9 no flag");
    step(7, 'h00, 0, 1, "R5 wrc / R8");
    step(9, 'h00, 0, 1, "R6 reset cmd keeps flag");
    step(0, 'h00, 0, 1, "R7 none->default");
    step(12, 'h00, 0, 1, "R7 unused code");
    step(15, 'h00, 0, 1, "R7 unused code");
    step(1, 'h00, 0, 0, "R10 oe low");
    step(2, 'h11, 0, 0, "R10 oe low load");
    step(1, 'h00, 0, 1, "R10 oe high");
    step(9, 'h00, 1, 1, "R6 reset cmd with clear");
    step(3, 'h00, 1, 1, "R9 inc with clear");

    step(2, 'h99, 0, 1, "R8 flag before reset");
    do_reset();

    seed = 32'h1234_5678;
    for (int i = 0; i < 300; i++) begin
      seed = seed ^ (seed << 13);
      seed = seed ^ (seed >>> 17);
      seed = seed ^ (seed << 5);
      step(seed & 'hF, (seed >> 4) & MASK, seed[9] & seed[10], seed[11] | seed[12],
           "R7 mixed stream");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule